// File: doc/BRIEF.md
# Privilege-Level Access Trap Decoder

This block decides what happens when software at a given privilege level tries to read or write one privileged control register. Each access is presented with a one-cycle strobe, the current privilege level (0 to 3) and a set of control flags. One cycle later the block reports a single result: the access is allowed, it is undefined, it traps to the top privilege level, or it traps to the hypervisor level. A trap also reports a fixed syndrome class code.

The checks run in a fixed priority order. The order is: feature presence, then the level-0 rule, then the two top-level trap controls, then the hypervisor trap control. A debug-state priority flag lets a top-level trap come back as undefined before any trap is taken. Reads and writes go through the same decision. The register contents and the exception entry sequence sit outside this block.

Top module: `ctrl_access_trap`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid_o` is 0 and `rsp_code_o` is 0 until the first strobe.
- R2: When `feat_present_i` is 0, every access reports undefined (`rsp_code_o` = 4'b0010).
- R3: When the feature is present, an access at level 0 reports undefined.
- R4: When the feature is present, an access at level 3 reports allow (`rsp_code_o` = 4'b0001).
- R5: At level 1 or 2, a top-level trap condition exists only when `top_present_i` is 1. It holds when `legacy_trap_i` is 1 and `legacy_ver_i` is 1, or when `bw_trap_n_i` is 0.
- R6: At level 1 or 2, if a top-level trap condition holds and `dbg_undef_prio_i` is 1, the result is undefined.
- R7: At level 1 or 2, if a top-level trap condition holds and `dbg_undef_prio_i` is 0, the result is undefined when `dbg_undef_i` is 1. Otherwise it is a trap to the top level (`rsp_code_o` = 4'b0100).
- R8: At level 1 only, with no top-level trap condition, the access traps to the hypervisor (`rsp_code_o` = 4'b1000) when `hyp_en_i` is 1 and `hyp_trap_n_i` is 0. In every other such case it is allowed.
- R9: `rsp_valid_o` is 1 in exactly the cycle after a cycle with `req_valid_i` = 1. While it is 1, exactly one bit of `rsp_code_o` is set.
- R10: `req_write_i` has no effect on the result.
- R11: `rsp_syndrome_o` is 6'h18 on either trap result and 0 on allow or undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cur_level_i | input | 2 | Current privilege level |
| feat_present_i | input | 1 | Feature implemented |
| top_present_i | input | 1 | Top privilege level exists |
| hyp_en_i | input | 1 | Hypervisor level enabled |
| legacy_ver_i | input | 1 | Legacy partitioning version present |
| legacy_trap_i | input | 1 | Legacy trap-lower control, active high |
| bw_trap_n_i | input | 1 | Bandwidth trap-lower control, active low |
| hyp_trap_n_i | input | 1 | Hypervisor trap control for this register, active low |
| dbg_undef_prio_i | input | 1 | Debug-state undefined takes priority |
| dbg_undef_i | input | 1 | Debug-state undefined in effect |
| rsp_valid_o | output | 1 | Result valid |
| rsp_code_o | output | 4 | One-hot result: bit0 allow, bit1 undefined, bit2 trap top, bit3 trap hypervisor |
| rsp_syndrome_o | output | 6 | Syndrome class for traps |

## Verification
The bench sweeps every combination of level, flags and direction. It targets four corner cases. The first is the legacy trap bit with its version flag absent: a design that ignores the version flag would trap where it must allow. The second is the debug priority flag turning a top-level trap into undefined: a design with the order wrong would trap instead. The third is level 2 with the hypervisor trap control low: a design that applies the hypervisor check at both levels would wrongly trap to the hypervisor. The fourth is a top-level trap and a hypervisor trap active at once, where a wrong priority reports the hypervisor trap.

// File: rtl/ctrl_trap_pkg.sv
package ctrl_trap_pkg;
  localparam int unsigned LVL_W = 2;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SYN_W = 6;
  localparam logic [SYN_W-1:0] TRAP_SYN = 6'h18;

  typedef enum logic [CODE_W-1:0] {
    RES_NONE  = 4'b0000,
    RES_ALLOW = 4'b0001,
    RES_UNDEF = 4'b0010,
    RES_TOP   = 4'b0100,
    RES_HYP   = 4'b1000
  } trap_res_e;

  typedef struct packed {
    logic lvl0;
    logic lvl1;
    logic lvl2;
    logic lvl3;
  } lvl_dec_t;
endpackage

// File: rtl/ctrl_trap_cond.sv
module ctrl_trap_cond
  import ctrl_trap_pkg::*;
(
  input  logic [LVL_W-1:0] cur_level_i,
  input  logic             top_present_i,
  input  logic             hyp_en_i,
  input  logic             legacy_ver_i,
  input  logic             legacy_trap_i,
  input  logic             bw_trap_n_i,
  input  logic             hyp_trap_n_i,
  output lvl_dec_t         lvl_o,
  output logic             top_hit_o,
  output logic             hyp_hit_o
);
  logic legacy_hit, bw_hit;

  always_comb begin
    lvl_o.lvl0 = (cur_level_i == 2'd0);
    lvl_o.lvl1 = (cur_level_i == 2'd1);
    lvl_o.lvl2 = (cur_level_i == 2'd2);
    lvl_o.lvl3 = (cur_level_i == 2'd3);
  end

  assign legacy_hit = legacy_ver_i & legacy_trap_i;
  assign bw_hit     = ~bw_trap_n_i;
  assign top_hit_o  = top_present_i & (legacy_hit | bw_hit);
  assign hyp_hit_o  = lvl_o.lvl1 & hyp_en_i & ~hyp_trap_n_i;

  always_comb begin
    assert_lvl_onehot_R3: assert ($countones(lvl_o) == 1);
  end
endmodule

// File: rtl/ctrl_trap_prio.sv
module ctrl_trap_prio
  import ctrl_trap_pkg::*;
(
  input  logic      feat_present_i,
  input  lvl_dec_t  lvl_i,
  input  logic      top_hit_i,
  input  logic      hyp_hit_i,
  input  logic      dbg_undef_prio_i,
  input  logic      dbg_undef_i,
  output trap_res_e res_o
);
  // Strict priority chain, first match wins
  always_comb begin
    if (!feat_present_i)                 res_o = RES_UNDEF;
    else if (lvl_i.lvl0)                 res_o = RES_UNDEF;
    else if (lvl_i.lvl3)                 res_o = RES_ALLOW;
    else if (top_hit_i && dbg_undef_prio_i) res_o = RES_UNDEF;
    else if (top_hit_i && dbg_undef_i)   res_o = RES_UNDEF;
    else if (top_hit_i)                  res_o = RES_TOP;
    else if (hyp_hit_i)                  res_o = RES_HYP;
    else                                 res_o = RES_ALLOW;
  end

  always_comb begin
    assert_nofeat_undef_R2: assert (feat_present_i || res_o == RES_UNDEF);
    assert_top_over_hyp_R8: assert (!(res_o == RES_HYP && top_hit_i));
  end
endmodule

// File: rtl/ctrl_access_trap.sv
module ctrl_access_trap
  import ctrl_trap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [LVL_W-1:0] cur_level_i,
  input  logic             feat_present_i,
  input  logic             top_present_i,
  input  logic             hyp_en_i,
  input  logic             legacy_ver_i,
  input  logic             legacy_trap_i,
  input  logic             bw_trap_n_i,
  input  logic             hyp_trap_n_i,
  input  logic             dbg_undef_prio_i,
  input  logic             dbg_undef_i,
  output logic             rsp_valid_o,
  output logic [CODE_W-1:0] rsp_code_o,
  output logic [SYN_W-1:0] rsp_syndrome_o
);
  lvl_dec_t  lvl;
  logic      top_hit, hyp_hit;
  trap_res_e res;
  logic      is_trap;

  ctrl_trap_cond u_cond (
    .cur_level_i   (cur_level_i),
    .top_present_i (top_present_i),
    .hyp_en_i      (hyp_en_i),
    .legacy_ver_i  (legacy_ver_i),
    .legacy_trap_i (legacy_trap_i),
    .bw_trap_n_i   (bw_trap_n_i),
    .hyp_trap_n_i  (hyp_trap_n_i),
    .lvl_o         (lvl),
    .top_hit_o     (top_hit),
    .hyp_hit_o     (hyp_hit)
  );

  ctrl_trap_prio u_prio (
    .feat_present_i   (feat_present_i),
    .lvl_i            (lvl),
    .top_hit_i        (top_hit),
    .hyp_hit_i        (hyp_hit),
    .dbg_undef_prio_i (dbg_undef_prio_i),
    .dbg_undef_i      (dbg_undef_i),
    .res_o            (res)
  );

  assign is_trap = (res == RES_TOP) || (res == RES_HYP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_code_o     <= '0;
      rsp_syndrome_o <= '0;
    end else begin
      rsp_valid_o    <= req_valid_i;
      rsp_code_o     <= req_valid_i ? res : '0;
      rsp_syndrome_o <= (req_valid_i && is_trap) ? TRAP_SYN : '0;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && rsp_code_o == '0);
  assert_code_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones(rsp_code_o) == 1);
  assert_trap_syn_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_code_o[2] || rsp_code_o[3]) |-> rsp_syndrome_o == TRAP_SYN);
  assert_lvl0_undef_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cur_level_i == 2'd0) |=> rsp_code_o == RES_UNDEF);
  assert_lvl3_allow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && feat_present_i && cur_level_i == 2'd3) |=> rsp_code_o == RES_ALLOW);
  assert_write_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> rsp_valid_o);
endmodule

// File: tb/ctrl_access_trap_test.sv
module ctrl_access_trap_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, wr = 1'b0;
  logic [1:0] lvl = 2'd0;
  logic feat = 0, topp = 0, hen = 0, lver = 0, ltrap = 0, bwn = 1, hn = 1, dprio = 0, dund = 0;
  logic rv;
  logic [3:0] rc;
  logic [5:0] rs;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctrl_access_trap uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr),
    .cur_level_i(lvl), .feat_present_i(feat), .top_present_i(topp),
    .hyp_en_i(hen), .legacy_ver_i(lver), .legacy_trap_i(ltrap),
    .bw_trap_n_i(bwn), .hyp_trap_n_i(hn), .dbg_undef_prio_i(dprio),
    .dbg_undef_i(dund), .rsp_valid_o(rv), .rsp_code_o(rc), .rsp_syndrome_o(rs)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (lvl=%0d f=%b tp=%b he=%b lv=%b lt=%b bn=%b hn=%b dp=%b du=%b w=%b)",
               req, act, exp, lvl, feat, topp, hen, lver, ltrap, bwn, hn, dprio, dund, wr);
    end
  endtask

  // Expected code from the requirement text
  function automatic logic [3:0] expect_code();
    logic top_cond;
    top_cond = topp && ((ltrap && lver) || !bwn);            // R5
    if (!feat) return 4'b0010;                               // R2
    if (lvl == 2'd0) return 4'b0010;                         // R3
    if (lvl == 2'd3) return 4'b0001;                         // R4
    if (top_cond) return (dprio || dund) ? 4'b0010 : 4'b0100; // R6 R7
    if (lvl == 2'd1 && hen && !hn) return 4'b1000;           // R8
    return 4'b0001;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {7'd0, rv}, 8'd0);
    chk("R1 code in reset", {4'd0, rc}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {7'd0, rv}, 8'd0);
    chk("R1 code after reset", {4'd0, rc}, 8'd0);

    for (int v = 0; v < 4096; v++) begin
      logic [3:0] e;
      {wr, lvl, feat, topp, hen, lver, ltrap, bwn, hn, dprio, dund} = v[11:0];
      vld = 1'b1;
      e = expect_code();
      @(negedge clk);
      chk("R9 valid after strobe", {7'd0, rv}, 8'd1);
      if (!feat)                   chk("R2 no feature", {4'd0, rc}, {4'd0, e});
      else if (lvl == 2'd0)        chk("R3 level0", {4'd0, rc}, {4'd0, e});
      else if (lvl == 2'd3)        chk("R4 level3", {4'd0, rc}, {4'd0, e});
      else if (e == 4'b0100)       chk("R7 top trap", {4'd0, rc}, {4'd0, e});
      else if (e == 4'b0010 && dprio) chk("R6 debug priority", {4'd0, rc}, {4'd0, e});
      else if (e == 4'b0010)       chk("R7 debug undef", {4'd0, rc}, {4'd0, e});
      else if (e == 4'b1000)       chk("R8 hyp trap", {4'd0, rc}, {4'd0, e});
      else                         chk("R5 R8 allow", {4'd0, rc}, {4'd0, e});
      chk("R11 syndrome", {2'd0, rs}, (e[2] || e[3]) ? 8'h18 : 8'h00);
      if (wr) chk("R10 write same as read", {4'd0, rc}, {4'd0, e});
    end

    // No strobe: no response whatever the inputs
    vld = 1'b0;
    for (int v = 0; v < 16; v++) begin
      {lvl, feat, topp} = v[3:0];
      @(negedge clk);
      chk("R9 no strobe valid", {7'd0, rv}, 8'd0);
      chk("R9 no strobe code", {4'd0, rc}, 8'd0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule